// File: doc/BRIEF.md
# BCD Decade Counter Digit with Cascade Carry

This block is one decimal digit of a synchronous counter. It holds a 4-bit state that steps through the codes 0 to 9 in 8421 weighting on each rising clock edge when counting is allowed. It can be preset from a 4-bit data input, which makes it useful as a programmable divider. A terminal-count flag marks the last decimal code so that several digits can be chained into one wide synchronous decimal counter.

Counting needs two enables at once. The chain enable is also the only enable that gates the carry flag, so a carry can ripple ahead through a chain of digits within one cycle. The local enable only pauses the digit it drives.

An elaboration parameter picks the reset style. The reset can be asynchronous and override everything, including the clock. It can instead be synchronous, taking effect at the next edge with priority over preset and counting.

Top module: `bcd_decade_counter`

## Requirements
- R1: With `ASYNC_CLR`=1, a low `rst_n` forces `digit` to 0 at once, without waiting for a clock edge. It holds `digit` at 0 through any clock edges for as long as it stays low, whatever the other inputs are.
- R2: With `ASYNC_CLR`=0, a low `rst_n` has no effect until the next rising edge. At that edge `digit` becomes 0, even when a preset is requested and both enables are high.
- R3: When `load_n` is 0 at a rising edge and no reset applies, `digit` takes `load_val` at that edge. This holds for every 4-bit value, including 10 to 15, and whatever the enables are.
- R4: When `load_n` is 1 and `en_par` and `en_chain` are both 1, each rising edge moves `digit` from a code n in 0..8 to n+1, and from 9 to 0.
- R5: When `load_n` is 1 and either enable is 0, `digit` keeps its value across the edge.
- R6: `carry_out` is 1 exactly when `digit` equals 9 and `en_chain` is 1. It does not depend on `en_par` or `load_n`.
- R7: From a code in 10..15, each enabled count edge adds one in binary, and 15 goes to 0. The digit therefore never stays in an unused code.
- R8: Apart from the asynchronous reset of R1, `digit` changes only at a rising clock edge. Input changes between edges do not move it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous or synchronous per `ASYNC_CLR` |
| load_n | input | 1 | Active-low preset request |
| load_val | input | 4 | Value taken by the digit on a preset |
| en_par | input | 1 | Local count enable; does not affect the carry |
| en_chain | input | 1 | Cascade count enable; also gates the carry |
| digit | output | 4 | Current digit state, 8421 coded |
| carry_out | output | 1 | High when the digit is 9 and `en_chain` is high |

## Verification
Preset, count, hold and synchronous reset all take effect one rising edge after the inputs that request them. The bench drives those inputs on the falling edge and reads `digit` 1 ns after the following rising edge. `carry_out` and the asynchronous reset are combinational with respect to their inputs. The bench therefore checks them 1 ns after driving the input, before any clock edge, and also checks that the synchronous-mode digit has not yet moved at that instant. The bench sweeps every preset value against every enable pair, and runs a free count through several wraps in both reset modes.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

    localparam int DIGIT_W   = 4;
    localparam int LAST_CODE = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } step_op_e;

    typedef struct packed {
        logic clr_req;
        logic load_req;
        logic run_req;
    } ctrl_t;

    function automatic logic is_last(digit_t d);
        return d == digit_t'(LAST_CODE);
    endfunction

    // Unused codes fall through a plain binary increment (15 wraps to 0).
    function automatic digit_t step_code(digit_t d);
        if (is_last(d)) begin
            return '0;
        end
        return d + digit_t'(1);
    endfunction

endpackage

// File: rtl/bcd_op_decode.sv
module bcd_op_decode
    import bcd_cnt_pkg::*;
(
    input  ctrl_t    ctrl,
    output step_op_e op
);
    always_comb begin
        if (ctrl.clr_req) begin
            op = OP_CLEAR;
        end else if (ctrl.load_req) begin
            op = OP_LOAD;
        end else if (ctrl.run_req) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end
endmodule

// File: rtl/bcd_next_state.sv
module bcd_next_state
    import bcd_cnt_pkg::*;
(
    input  step_op_e op,
    input  digit_t   cur,
    input  digit_t   preset,
    output digit_t   nxt
);
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset;
            OP_STEP:  nxt = step_code(cur);
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg
    import bcd_cnt_pkg::*;
#(
    parameter bit ASYNC_CLR = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  digit_t d,
    output digit_t q
);
    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end
        end else begin : g_sync
            // Clear arrives through the next-state path as OP_CLEAR.
            always_ff @(posedge clk) begin
                q <= d;
            end
        end
    endgenerate
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
    import bcd_cnt_pkg::*;
#(
    parameter bit ASYNC_CLR = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load_n,
    input  logic [bcd_cnt_pkg::DIGIT_W-1:0]     load_val,
    input  logic                                en_par,
    input  logic                                en_chain,
    output logic [bcd_cnt_pkg::DIGIT_W-1:0]     digit,
    output logic                                carry_out
);
    ctrl_t    ctrl;
    step_op_e op;
    digit_t   state_q;
    digit_t   state_d;

    always_comb begin
        ctrl.clr_req  = !ASYNC_CLR && !rst_n;
        ctrl.load_req = !load_n;
        ctrl.run_req  = en_par && en_chain;
    end

    bcd_op_decode u_dec (
        .ctrl (ctrl),
        .op   (op)
    );

    bcd_next_state u_nxt (
        .op     (op),
        .cur    (state_q),
        .preset (load_val),
        .nxt    (state_d)
    );

    bcd_state_reg #(.ASYNC_CLR(ASYNC_CLR)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (state_d),
        .q     (state_q)
    );

    assign digit     = state_q;
    assign carry_out = en_chain && is_last(state_q);
endmodule

// File: rtl/bcd_counter_chk.sv
module bcd_counter_chk #(
    parameter bit ASYNC_CLR = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       load_n,
    input logic [3:0] load_val,
    input logic       en_par,
    input logic       en_chain,
    input logic [3:0] digit,
    input logic       carry_out
);
    logic seen_edge = 1'b0;
    logic rst_seen  = 1'b0;

    always @(posedge clk) begin
        seen_edge <= 1'b1;
        rst_seen  <= !rst_n;
    end

    // R1
    generate
        if (ASYNC_CLR) begin : g_async_chk
            always @(posedge clk) begin
                if (seen_edge && !rst_n) begin
                    async_clear_chk: assert (digit == 4'd0);
                end
            end
        end
    endgenerate

    // R2
    reset_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |-> digit == 4'd0);

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> digit == $past(load_val));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_chain && digit < 4'd9) |=> digit == $past(digit) + 4'd1);

    // R4
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_chain && digit == 4'd9) |=> digit == 4'd0);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_par && en_chain)) |=> $stable(digit));

    // R6
    carry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_chain |-> !carry_out);

    // R6
    carry_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> digit == 4'd9);

    // R7
    unused_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_chain && digit > 4'd9) |=> digit == $past(digit) + 4'd1);
endmodule

bind bcd_decade_counter bcd_counter_chk #(.ASYNC_CLR(ASYNC_CLR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .load_val  (load_val),
    .en_par    (en_par),
    .en_chain  (en_chain),
    .digit     (digit),
    .carry_out (carry_out)
);

// File: tb/test_bcd_decade_counter.sv
`timescale 1ns/1ps
module test_bcd_decade_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] load_val = 4'd0;
    logic       en_par = 1'b0;
    logic       en_chain = 1'b0;
    logic [3:0] dig_a, dig_s;
    logic       cy_a, cy_s;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_decade_counter #(.ASYNC_CLR(1'b1)) i_bcd_decade_counter (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(load_val),
        .en_par(en_par), .en_chain(en_chain), .digit(dig_a), .carry_out(cy_a));

    bcd_decade_counter #(.ASYNC_CLR(1'b0)) i_bcd_decade_counter_sync (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(load_val),
        .en_par(en_par), .en_chain(en_chain), .digit(dig_s), .carry_out(cy_s));

    function automatic int model_next(int v);
        if (v < 10) return (v + 1) % 10;
        return (v + 1) % 16;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_slot();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ref_v;
        // Reset state, R1 and R2
        after_edge();
        after_edge();
        chk("R1 reset state", dig_a, 0);
        chk("R2 reset state", dig_s, 0);
        chk("R6 reset carry", cy_a, 0);
        drive_slot();
        rst_n = 1'b1;

        // Sweep: every preset value against every enable pair
        for (int v = 0; v < 16; v++) begin
            for (int e = 0; e < 4; e++) begin
                drive_slot();
                load_n = 1'b0;
                load_val = 4'(v);
                en_par = e[0];
                en_chain = e[1];
                after_edge();
                chk("R3 preset async-mode", dig_a, v);
                chk("R3 preset sync-mode", dig_s, v);
                chk("R6 carry", cy_a, (v == 9 && e[1]) ? 1 : 0);
                chk("R6 carry sync-mode", cy_s, (v == 9 && e[1]) ? 1 : 0);
                drive_slot();
                load_n = 1'b1;
                #1;
                chk("R6 carry after load_n rises", cy_a, (v == 9 && e[1]) ? 1 : 0);
                after_edge();
                ref_v = (e == 3) ? model_next(v) : v;
                if (e != 3) chk("R5 hold", dig_a, ref_v);
                else if (v > 9) chk("R7 unused code step", dig_a, ref_v);
                else chk("R4 count step", dig_a, ref_v);
                chk("R4 count step sync-mode", dig_s, ref_v);
            end
        end

        // Free count through several wraps
        drive_slot();
        load_n = 1'b0;
        load_val = 4'd0;
        after_edge();
        drive_slot();
        load_n = 1'b1;
        en_par = 1'b1;
        en_chain = 1'b1;
        ref_v = 0;
        for (int i = 0; i < 30; i++) begin
            after_edge();
            ref_v = (ref_v + 1) % 10;
            chk("R4 free count", dig_a, ref_v);
            chk("R4 free count sync-mode", dig_s, ref_v);
            chk("R6 carry in count", cy_a, (ref_v == 9) ? 1 : 0);
        end

        // Carry does not depend on en_par
        drive_slot();
        load_n = 1'b0;
        load_val = 4'd9;
        after_edge();
        drive_slot();
        load_n = 1'b1;
        en_par = 1'b0;
        en_chain = 1'b1;
        #1;
        chk("R6 carry with en_par low", cy_a, 1);
        en_chain = 1'b0;
        #1;
        chk("R6 carry with en_chain low", cy_a, 0);

        // State moves only on the rising edge
        drive_slot();
        load_n = 1'b0;
        load_val = 4'd5;
        en_par = 1'b1;
        en_chain = 1'b1;
        #1;
        chk("R8 no change before edge", dig_a, 9);
        chk("R8 no change before edge sync-mode", dig_s, 9);
        after_edge();
        chk("R8 change at edge", dig_a, 5);

        // Reset priority: async clears at once, sync waits for the edge
        drive_slot();
        rst_n = 1'b0;
        load_n = 1'b0;
        load_val = 4'd7;
        #1;
        chk("R1 async clear without edge", dig_a, 0);
        chk("R2 sync clear waits for edge", dig_s, 5);
        after_edge();
        chk("R1 async clear held over edge", dig_a, 0);
        chk("R2 sync clear beats preset and count", dig_s, 0);
        after_edge();
        chk("R1 async clear still held", dig_a, 0);
        drive_slot();
        rst_n = 1'b1;
        after_edge();
        chk("R3 preset after reset release", dig_a, 7);
        chk("R3 preset after reset release sync-mode", dig_s, 7);

        finish_run();
    end
endmodule